// File: doc/BRIEF.md
# Programmable Interval Timer with Waveform Output

This block is a 32-bit up-counting timer reached through a small single-cycle register bus. Software programs a start value, a reload value and a compare value, picks an optional clock divider, and starts the count. When the count passes its all-ones value it wraps. It then either reloads the programmed value and keeps running, or stops at zero. A compare unit can flag the cycle in which the count reaches a chosen value. Both events set sticky status bits, and those bits raise an interrupt when they are enabled.

A waveform output follows the same events. It can give a one-clock pulse away from a programmable idle level, or it can change state on every selected event. Used with auto-reload, this gives a periodic tick or a square wave. A write to a trigger register copies the reload value into the counter, so software can restart a period at any time. A write to the reset register clears every register over a few cycles, and a done flag shows when that is finished. A write-pending register shows which register write is still being applied.

Top module: `gp_timer_pwm`

## Requirements
- R1: After reset, the control (0x24), counter (0x28), reload (0x2C), status (0x18) and pending (0x34) registers read 0. The reset-done flag (bit 0 of 0x14) reads 1, and irqOut and pwmOut are 0.
- R2: With control bit 0 set and bit 5 clear, the counter goes up by one on every clock. With bit 0 clear, the counter holds its value.
- R3: With control bit 5 set, the counter goes up once every 2^(v+1) clocks, where v is the 3-bit value in control bits 4:2.
- R4: When the counter steps past 0xFFFFFFFF, status bit 1 is set. If control bit 1 is set, the counter takes the reload value. Otherwise it goes to 0 and control bit 0 is cleared.
- R5: Any write to the trigger register (0x30) copies the reload value into the counter.
- R6: A write to 0x28 sets the counter to the written value.
- R7: With control bit 6 set, status bit 0 is set on the step that makes the counter equal the compare register (0x38). With bit 6 clear, it is not set.
- R8: Writing 1 to a status bit clears it. irqOut is the OR of the status bits ANDed with the matching enable bits at 0x1C (bit 0 compare, bit 1 wrap).
- R9: The pending register reads a one-hot bit for the cycle after a register write: bit 0 control, bit 1 counter, bit 2 reload, bit 3 trigger, bit 4 compare. After that it reads 0.
- R10: A write to 0x40 with bit 1 set (for example 0x06) clears all registers. While this runs the done flag reads 0, and it reads 1 again RST_CYCLES cycles after the write.
- R11: Control bits 11:10 choose which events drive pwmOut: 1 selects wrap only, 2 or 3 select wrap and compare. With bit 12 clear, pwmOut is the inverse of the idle level for one clock on each selected event.
- R12: With bit 12 set, pwmOut inverts on each selected event and keeps its level between events.
- R13: While control bits 11:10 are 0, pwmOut follows the idle level in control bit 7. It reaches that level one clock after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one register write per cycle |
| busRdEn | input | 1 | Read enable; read data is 0 when low |
| busAddr | input | 8 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| irqOut | output | 1 | Level interrupt from enabled status bits |
| pwmOut | output | 1 | Registered waveform output |

## Verification
The properties assume that the bus carries at most one write per cycle. They also assume that a counter write, a trigger write and a soft-reset window never overlap in a way the datapath priority does not cover. Overflow and match checks are written only for steps taken by the count path itself. The directed tasks stop the counter before they reprogram it and issue one write per clock through a single bus task. They also clear status before each scenario, so every event seen comes from the stimulus under test.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] ADDR_SYS   = 8'h14;
  localparam logic [7:0] ADDR_STAT  = 8'h18;
  localparam logic [7:0] ADDR_IEN   = 8'h1C;
  localparam logic [7:0] ADDR_CTRL  = 8'h24;
  localparam logic [7:0] ADDR_COUNT = 8'h28;
  localparam logic [7:0] ADDR_LOAD  = 8'h2C;
  localparam logic [7:0] ADDR_TRIG  = 8'h30;
  localparam logic [7:0] ADDR_PEND  = 8'h34;
  localparam logic [7:0] ADDR_MATCH = 8'h38;
  localparam logic [7:0] ADDR_IFC   = 8'h40;

  // implemented control bits: 0..7 and 10..12
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h0000_1CFF;

  typedef struct packed {
    logic             start;
    logic             autoReload;
    logic             preEn;
    logic [2:0]       preVal;
    logic             cmpEn;
    logic             cntWr;
    logic             trigLoad;
    logic             softClr;
    logic [REG_W-1:0] wrData;
    logic [REG_W-1:0] loadVal;
    logic [REG_W-1:0] matchVal;
  } tmrCtl_t;

  typedef struct packed {
    logic [REG_W-1:0] count;
    logic             ovfEvt;
    logic             matchEvt;
  } tmrEvt_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int PRE_BITS = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  tmrCtl_t ctl,
  output tmrEvt_t evt
);
  localparam int PCW = 1 << PRE_BITS;

  logic [PCW-1:0]   preCnt;
  logic [PCW-1:0]   preLimit;
  logic [REG_W-1:0] count;
  logic [REG_W-1:0] nextCnt;
  logic             tick;
  logic             wrapNow;
  logic             busOwns;

  assign preLimit = (PCW'(2) << ctl.preVal) - PCW'(1);
  assign tick     = ctl.start && (!ctl.preEn || (preCnt == preLimit));
  assign wrapNow  = &count;
  assign busOwns  = ctl.cntWr || ctl.trigLoad || ctl.softClr;
  assign nextCnt  = wrapNow ? (ctl.autoReload ? ctl.loadVal : '0) : count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (ctl.softClr || !ctl.start || !ctl.preEn || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ctl.softClr) begin
      count <= '0;
    end else if (ctl.cntWr) begin
      count <= ctl.wrData;
    end else if (ctl.trigLoad) begin
      count <= ctl.loadVal;
    end else if (tick) begin
      count <= nextCnt;
    end
  end

  assign evt.count    = count;
  assign evt.ovfEvt   = tick && !busOwns && wrapNow;
  assign evt.matchEvt = tick && !busOwns && ctl.cmpEn && (nextCnt == ctl.matchVal);
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [7:0]       busAddr,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] busRdData,
  input  tmrEvt_t          evt,
  output tmrCtl_t          ctl,
  output logic             irqOut,
  output logic             pwmOut
);
  localparam int RCW = $clog2(RST_CYCLES + 1);
  localparam int NPEND = 5;

  logic [REG_W-1:0] ctrlReg, loadReg, matchReg;
  logic [1:0]       statReg, ienReg;
  logic [NPEND-1:0] pendReg, wrVec;
  logic [RCW-1:0]   rstCnt;
  logic             busy, pwmReg, pwmEvt;
  logic             wrCtrl, wrCount, wrLoad, wrTrig, wrMatch, wrStat, wrIen, wrIfc;
  logic [1:0]       trigSel;

  assign busy    = (rstCnt != '0);
  assign wrCtrl  = busWrEn && !busy && (busAddr == ADDR_CTRL);
  assign wrCount = busWrEn && !busy && (busAddr == ADDR_COUNT);
  assign wrLoad  = busWrEn && !busy && (busAddr == ADDR_LOAD);
  assign wrTrig  = busWrEn && !busy && (busAddr == ADDR_TRIG);
  assign wrMatch = busWrEn && !busy && (busAddr == ADDR_MATCH);
  assign wrStat  = busWrEn && !busy && (busAddr == ADDR_STAT);
  assign wrIen   = busWrEn && !busy && (busAddr == ADDR_IEN);
  assign wrIfc   = busWrEn && !busy && (busAddr == ADDR_IFC) && busWrData[1];
  assign wrVec   = {wrMatch, wrTrig, wrLoad, wrCount, wrCtrl};

  assign trigSel = ctrlReg[11:10];
  assign pwmEvt  = ((trigSel != 2'd0) && evt.ovfEvt) || (trigSel[1] && evt.matchEvt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0; loadReg <= '0; matchReg <= '0;
      statReg <= '0; ienReg <= '0; pendReg <= '0;
      rstCnt  <= '0; pwmReg <= 1'b0;
    end else if (busy) begin
      ctrlReg <= '0; loadReg <= '0; matchReg <= '0;
      statReg <= '0; ienReg <= '0; pendReg <= '0;
      rstCnt  <= rstCnt - 1'b1; pwmReg <= 1'b0;
    end else begin
      pendReg <= wrVec;
      if (wrIfc) rstCnt <= RCW'(RST_CYCLES);
      if (wrCtrl)                                 ctrlReg    <= busWrData & CTRL_MASK;
      else if (evt.ovfEvt && !ctrlReg[1])         ctrlReg[0] <= 1'b0;
      if (wrLoad)  loadReg  <= busWrData;
      if (wrMatch) matchReg <= busWrData;
      if (wrIen)   ienReg   <= busWrData[1:0];
      statReg <= (statReg & ~(wrStat ? busWrData[1:0] : 2'b00))
               | {evt.ovfEvt, evt.matchEvt};
      if (trigSel == 2'd0)  pwmReg <= ctrlReg[7];
      else if (ctrlReg[12]) pwmReg <= pwmEvt ? ~pwmReg : pwmReg;
      else                  pwmReg <= pwmEvt ? ~ctrlReg[7] : ctrlReg[7];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        ADDR_SYS:   busRdData = {{(REG_W-1){1'b0}}, !busy};
        ADDR_STAT:  busRdData = {{(REG_W-2){1'b0}}, statReg};
        ADDR_IEN:   busRdData = {{(REG_W-2){1'b0}}, ienReg};
        ADDR_CTRL:  busRdData = ctrlReg;
        ADDR_COUNT: busRdData = evt.count;
        ADDR_LOAD:  busRdData = loadReg;
        ADDR_PEND:  busRdData = {{(REG_W-NPEND){1'b0}}, pendReg};
        ADDR_MATCH: busRdData = matchReg;
        default:    busRdData = '0;
      endcase
    end
  end

  always_comb begin
    ctl.start      = ctrlReg[0];
    ctl.autoReload = ctrlReg[1];
    ctl.preVal     = ctrlReg[4:2];
    ctl.preEn      = ctrlReg[5];
    ctl.cmpEn      = ctrlReg[6];
    ctl.cntWr      = wrCount;
    ctl.trigLoad   = wrTrig;
    ctl.softClr    = busy;
    ctl.wrData     = busWrData;
    ctl.loadVal    = loadReg;
    ctl.matchVal   = matchReg;
  end

  assign irqOut = |(statReg & ienReg);
  assign pwmOut = pwmReg;
endmodule

// File: rtl/gp_timer_pwm.sv
module gp_timer_pwm
  import tmr_pkg::*;
#(
  parameter int PRE_BITS   = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqOut,
  output logic        pwmOut
);
  tmrCtl_t ctl;
  tmrEvt_t evt;

  tmr_control #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .evt(evt), .ctl(ctl), .irqOut(irqOut), .pwmOut(pwmOut)
  );

  tmr_datapath #(.PRE_BITS(PRE_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .evt(evt)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input tmrCtl_t     ctl,
  input tmrEvt_t     evt,
  input logic        busRdEn,
  input logic [7:0]  busAddr,
  input logic [31:0] busRdData
);
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.start && !ctl.cntWr && !ctl.trigLoad && !ctl.softClr) |=> $stable(evt.count)); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.ovfEvt && !ctl.autoReload) |=> (evt.count == '0)); // R4

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.ovfEvt && ctl.autoReload) |=> (evt.count == $past(ctl.loadVal))); // R4

  AST_TRIGGER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.trigLoad && !ctl.cntWr && !ctl.softClr) |=> (evt.count == $past(ctl.loadVal))); // R5

  AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    evt.matchEvt |=> (evt.count == $past(ctl.matchVal))); // R7

  AST_PEND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busAddr == ADDR_PEND) |-> ($onehot0(busRdData) && busRdData[31:5] == '0)); // R9
endmodule

bind gp_timer_pwm tmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .evt(evt),
  .busRdEn(busRdEn), .busAddr(busAddr), .busRdData(busRdData)
);

// File: tb/tb_gp_timer_pwm.sv
`timescale 1ns/1ps
module tb_gp_timer_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, pwmOut;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  localparam logic [7:0] A_SYS = 8'h14, A_STAT = 8'h18, A_IEN = 8'h1C, A_CTRL = 8'h24,
    A_COUNT = 8'h28, A_LOAD = 8'h2C, A_TRIG = 8'h30, A_PEND = 8'h34, A_MATCH = 8'h38, A_IFC = 8'h40;

  always #2.5 clk = ~clk;

  gp_timer_pwm dut (.clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .pwmOut(pwmOut));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    rdChk("R1 ctrl", A_CTRL, 0);
    rdChk("R1 count", A_COUNT, 0);
    rdChk("R1 load", A_LOAD, 0);
    rdChk("R1 status", A_STAT, 0);
    rdChk("R1 pend", A_PEND, 0);
    rdChk("R1 done", A_SYS, 1);
    check("R1 irq", {31'b0, irqOut}, 0);
    check("R1 pwm", {31'b0, pwmOut}, 0);
  endtask

  task automatic t_count();
    wr(A_COUNT, 0);
    wr(A_CTRL, 32'h1);
    idle(9);
    wr(A_CTRL, 32'h0);
    rdChk("R2 count after 10 clocks", A_COUNT, 10);
    idle(5);
    rdChk("R2 hold when stopped", A_COUNT, 10);
    wr(A_COUNT, 32'hABCD_0000);
    rdChk("R6 direct write", A_COUNT, 32'hABCD_0000);
  endtask

  task automatic t_prescale();
    wr(A_COUNT, 0);
    wr(A_CTRL, 32'h25);           // prescaler on, v=1 -> every 4 clocks
    idle(15);
    wr(A_CTRL, 0);
    rdChk("R3 v=1 over 16 clocks", A_COUNT, 4);
    wr(A_COUNT, 0);
    wr(A_CTRL, 32'h21);           // v=0 -> every 2 clocks
    idle(15);
    wr(A_CTRL, 0);
    rdChk("R3 v=0 over 16 clocks", A_COUNT, 8);
  endtask

  task automatic t_overflow();
    wr(A_STAT, 3);
    wr(A_LOAD, 32'h100);
    wr(A_COUNT, 32'hFFFF_FFFD);
    wr(A_CTRL, 32'h3);
    idle(3);
    rdChk("R4 reload on wrap", A_COUNT, 32'h100);
    rdChk("R4 wrap status", A_STAT, 2);
    wr(A_CTRL, 0);
    wr(A_STAT, 3);
    wr(A_COUNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1);
    idle(4);
    rdChk("R4 zero without reload", A_COUNT, 0);
    rdChk("R4 start cleared", A_CTRL, 0);
    rdChk("R4 wrap status no reload", A_STAT, 2);
    wr(A_STAT, 3);
  endtask

  task automatic t_trigger();
    wr(A_LOAD, 32'h55);
    wr(A_COUNT, 32'h9);
    wr(A_TRIG, 32'hDEAD);
    rdChk("R5 trigger load", A_COUNT, 32'h55);
  endtask

  task automatic t_match_irq();
    wr(A_COUNT, 0);
    wr(A_MATCH, 5);
    wr(A_STAT, 3);
    wr(A_IEN, 1);
    wr(A_CTRL, 32'h1);            // compare disabled
    idle(7);
    wr(A_CTRL, 0);
    rdChk("R7 no match without enable", A_STAT, 0);
    wr(A_COUNT, 0);
    wr(A_CTRL, 32'h41);
    idle(4);
    rdChk("R7 not yet at 4", A_STAT, 0);
    idle(1);
    rdChk("R7 match at 5", A_STAT, 1);
    check("R8 irq on enabled status", {31'b0, irqOut}, 1);
    wr(A_CTRL, 0);
    wr(A_STAT, 2);
    check("R8 write1 to other bit keeps", {31'b0, irqOut}, 1);
    wr(A_STAT, 1);
    rdChk("R8 cleared", A_STAT, 0);
    check("R8 irq low", {31'b0, irqOut}, 0);
    wr(A_IEN, 0);
  endtask

  task automatic t_pending();
    wr(A_LOAD, 32'h7);
    rdChk("R9 load pend", A_PEND, 32'h4);
    idle(1);
    rdChk("R9 pend cleared", A_PEND, 0);
    wr(A_TRIG, 0);
    rdChk("R9 trigger pend", A_PEND, 32'h8);
    wr(A_MATCH, 1);
    rdChk("R9 match pend", A_PEND, 32'h10);
  endtask

  task automatic t_softreset();
    wr(A_LOAD, 32'h1234);
    wr(A_CTRL, 32'h1);
    wr(A_IFC, 32'h6);
    rdChk("R10 busy", A_SYS, 0);
    idle(3);
    rdChk("R10 still busy", A_SYS, 0);
    idle(1);
    rdChk("R10 done", A_SYS, 1);
    rdChk("R10 load cleared", A_LOAD, 0);
    rdChk("R10 ctrl cleared", A_CTRL, 0);
    rdChk("R10 count cleared", A_COUNT, 0);
  endtask

  task automatic t_pwm_pulse();
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'hFFFF_FFFC);
    wr(A_COUNT, 32'hFFFF_FFFC);
    wr(A_CTRL, 32'h403);
    idle(3);
    check("R11 idle before wrap", {31'b0, pwmOut}, 0);
    idle(1);
    check("R11 pulse on wrap", {31'b0, pwmOut}, 1);
    idle(1);
    check("R11 pulse one clock", {31'b0, pwmOut}, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_pwm_toggle();
    wr(A_CTRL, 0);
    wr(A_COUNT, 32'hFFFF_FFFC);
    wr(A_CTRL, 32'h1403);
    idle(4);
    check("R12 toggle high", {31'b0, pwmOut}, 1);
    idle(3);
    check("R12 level held", {31'b0, pwmOut}, 1);
    idle(1);
    check("R12 toggle low", {31'b0, pwmOut}, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_pwm_match();
    wr(A_CTRL, 32'h80);
    idle(1);
    check("R13 idle level high", {31'b0, pwmOut}, 1);
    wr(A_COUNT, 0);
    wr(A_MATCH, 3);
    wr(A_CTRL, 32'h4C1);          // wrap-only source, compare on
    idle(4);
    check("R11 compare ignored with wrap source", {31'b0, pwmOut}, 1);
    wr(A_CTRL, 32'h80);
    wr(A_COUNT, 0);
    wr(A_CTRL, 32'h8C1);          // wrap and compare source
    idle(3);
    check("R11 pulse low on compare", {31'b0, pwmOut}, 0);
    idle(1);
    check("R11 back to idle", {31'b0, pwmOut}, 1);
    wr(A_CTRL, 0);
    idle(1);
    check("R13 idle level low", {31'b0, pwmOut}, 0);
    wr(A_STAT, 3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_count();
    t_prescale();
    t_overflow();
    t_trigger();
    t_match_irq();
    t_pending();
    t_softreset();
    t_pwm_pulse();
    t_pwm_toggle();
    t_pwm_match();
    finish_run();
  end
endmodule